// File: doc/BRIEF.md
# Hardware Fast A20 Gate Controller

This block follows the write traffic that a host sends to channel 1 of a host register interface. It drives the A20 gate output directly, so no firmware interrupt routine is needed. The host first writes the command byte 0xD1, which arms the block. The next data write then supplies the new gate value, which is bit 1 of that data byte. The block keeps the gate value in a register and drives the output pin from it.

The function has an enable bit. While the enable bit is clear, the block ignores host writes and holds its gate register at 1. The pin then shows a gate value that firmware supplies on a separate input. This means that each time the function is switched on, it starts with the gate at logic 1.

A pin-direction bit decides whether the pin is driven at all. When the direction is input, the output enable is low and the output level is held at 1.

Top module: `fast_a20_gate`

## Requirements
- R1: After synchronous reset, the gate register is 1 and the block is not armed. A data write made right after reset, with no 0xD1 command before it, leaves the pin at 1.
- R2: When the block is enabled and armed, a data write (host_is_cmd = 0) loads bit 1 of host_byte into the gate register. The new value is on gate_pin_o from the cycle after the write's clock edge.
- R3: A data write while the block is not armed leaves the gate value unchanged.
- R4: A command write (host_is_cmd = 1) with any byte other than 0xD1 clears the armed state. A data write after it does not change the gate.
- R5: Writing 0xD1 several times in a row keeps the block armed. One later data write still loads the gate.
- R6: The armed state clears when a data byte is consumed. A second data write does not change the gate.
- R7: While gate_en = 0, the block ignores host writes and holds the gate register at 1, and gate_pin_o shows fw_gate. After enable returns to 1, the pin shows 1.
- R8: When pin_dir_out = 0, gate_pin_oe is 0 and gate_pin_o is 1. When pin_dir_out = 1, gate_pin_oe is 1.
- R9: Bits of the data byte other than bit 1 have no effect on the gate value. This holds for all 256 byte values.
- R10: While host_wr is 0, changes on host_is_cmd and host_byte have no effect on the gate or on the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle strobe for a host write to channel 1 |
| host_is_cmd | input | 1 | 1 = command write, 0 = data write |
| host_byte | input | 8 | Byte written by the host |
| gate_en | input | 1 | Enables the hardware gate function |
| pin_dir_out | input | 1 | 1 = the gate pin is an output |
| fw_gate | input | 1 | Gate value from firmware, used while the function is disabled |
| gate_pin_o | output | 1 | Gate pin level |
| gate_pin_oe | output | 1 | Gate pin output enable |

## Verification
Each write takes effect at the clock edge where host_wr is high. The gate register and the armed flag are the only state on that path. A loaded gate value therefore appears on gate_pin_o one edge after the data write, and the bench checks it at the falling edge right after that write. The enable and direction bits reach the pin through combinational logic only, so their effect is checked half a cycle after they change, with no clock edge in between. The one exception is the forced 1 on the gate register, which takes one edge after the enable bit falls.

// File: rtl/a20_pkg.sv
package a20_pkg;

    localparam int HOST_W = 8;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CMD  = 1'b1
    } host_kind_e;

    typedef struct packed {
        logic              valid;
        host_kind_e        kind;
        logic [HOST_W-1:0] val;
    } host_wr_t;

    function automatic logic is_cmd_write(host_wr_t w);
        return w.valid && (w.kind == KIND_CMD);
    endfunction

    function automatic logic is_data_write(host_wr_t w);
        return w.valid && (w.kind == KIND_DATA);
    endfunction

endpackage

// File: rtl/a20_arm_detect.sv
module a20_arm_detect
    import a20_pkg::*;
#(
    parameter logic [HOST_W-1:0] ARM_CODE = 8'hD1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  host_wr_t wr,
    output logic     armed_q,
    output logic     load
);

    logic arm_hit;
    logic armed_d;

    assign arm_hit = is_cmd_write(wr) && (wr.val == ARM_CODE);
    assign load    = en && armed_q && is_data_write(wr);

    always_comb begin
        armed_d = armed_q;
        if (!en) begin
            armed_d = 1'b0;
        end else if (is_cmd_write(wr)) begin
            armed_d = arm_hit;
        end else if (is_data_write(wr)) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

    p_arm_on_code_r5: assert property (@(posedge clk) disable iff (rst)
        (en && wr.valid && wr.kind == KIND_CMD && wr.val == ARM_CODE) |=> armed_q);

    p_other_cmd_disarm_r4: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.kind == KIND_CMD && wr.val != ARM_CODE) |=> !armed_q);

    p_data_consumes_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.kind == KIND_DATA) |=> !armed_q);

    p_idle_keeps_arm_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr.valid && en) |=> (armed_q == $past(armed_q)));

endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg
    import a20_pkg::*;
#(
    parameter int SEL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [HOST_W-1:0] data,
    output logic              gate_q
);

    always_ff @(posedge clk) begin
        if (rst || !en) gate_q <= 1'b1;
        else if (load)  gate_q <= data[SEL_BIT];
    end

    p_load_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (gate_q == $past(data[SEL_BIT])));

    p_hold_unloaded_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (gate_q == $past(gate_q)));

    p_disabled_high_r7: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> gate_q);

endmodule

// File: rtl/a20_pin_drive.sv
module a20_pin_drive (
    input  logic en,
    input  logic dir_out,
    input  logic hw_gate,
    input  logic fw_gate,
    output logic pin_o,
    output logic pin_oe
);

    logic level;

    always_comb begin
        level  = en ? hw_gate : fw_gate;
        pin_oe = dir_out;
        pin_o  = dir_out ? level : 1'b1;
    end

endmodule

// File: rtl/fast_a20_gate.sv
module fast_a20_gate
    import a20_pkg::*;
#(
    parameter logic [HOST_W-1:0] ARM_CODE = 8'hD1,
    parameter int                SEL_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_is_cmd,
    input  logic [HOST_W-1:0] host_byte,
    input  logic              gate_en,
    input  logic              pin_dir_out,
    input  logic              fw_gate,
    output logic              gate_pin_o,
    output logic              gate_pin_oe
);

    host_wr_t wr;
    logic     armed_q;
    logic     load;
    logic     gate_q;

    assign wr.valid = host_wr;
    assign wr.kind  = host_is_cmd ? KIND_CMD : KIND_DATA;
    assign wr.val   = host_byte;

    a20_arm_detect #(.ARM_CODE(ARM_CODE)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .en      (gate_en),
        .wr      (wr),
        .armed_q (armed_q),
        .load    (load)
    );

    a20_gate_reg #(.SEL_BIT(SEL_BIT)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .en     (gate_en),
        .load   (load),
        .data   (host_byte),
        .gate_q (gate_q)
    );

    a20_pin_drive u_pin (
        .en      (gate_en),
        .dir_out (pin_dir_out),
        .hw_gate (gate_q),
        .fw_gate (fw_gate),
        .pin_o   (gate_pin_o),
        .pin_oe  (gate_pin_oe)
    );

    p_input_dir_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!pin_dir_out) |-> (gate_pin_o && !gate_pin_oe));

    p_fw_path_r7: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && pin_dir_out) |-> (gate_pin_o == fw_gate));

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (gate_q && !armed_q));

endmodule

// File: tb/fast_a20_gate_tb.sv
module fast_a20_gate_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_is_cmd = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       gate_en = 1'b0;
    logic       pin_dir_out = 1'b1;
    logic       fw_gate = 1'b0;
    logic       gate_pin_o;
    logic       gate_pin_oe;

    int checks = 0;
    int failures = 0;

    logic m_gate;
    logic m_armed;

    always #4 clk = ~clk;

    fast_a20_gate u_dut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_is_cmd (host_is_cmd),
        .host_byte   (host_byte),
        .gate_en     (gate_en),
        .pin_dir_out (pin_dir_out),
        .fw_gate     (fw_gate),
        .gate_pin_o  (gate_pin_o),
        .gate_pin_oe (gate_pin_oe)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // drive at falling edge, write is taken at next rising edge, sample at following falling edge
    task automatic hwrite(input logic is_cmd, input logic [7:0] b);
        host_wr = 1'b1;
        host_is_cmd = is_cmd;
        host_byte = b;
        @(negedge clk);
        host_wr = 1'b0;
        if (gate_en) begin
            if (is_cmd) m_armed = (b == 8'hD1);
            else if (m_armed) begin
                m_gate = b[1];
                m_armed = 1'b0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_gate = 1'b1;
        m_armed = 1'b0;
        idle(3);
        rst = 1'b0;
        gate_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset gate", gate_pin_o, 1'b1);
        hwrite(1'b0, 8'h00);
        chk("R1 unarmed after reset", gate_pin_o, 1'b1);

        // R2 basic load
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h00);
        chk("R2 load 0", gate_pin_o, 1'b0);
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h02);
        chk("R2 load 1", gate_pin_o, 1'b1);

        // R3 unarmed data write
        hwrite(1'b0, 8'h00);
        chk("R3 unarmed data", gate_pin_o, 1'b1);

        // R4 other command disarms
        hwrite(1'b1, 8'hD1);
        hwrite(1'b1, 8'hDD);
        hwrite(1'b0, 8'h00);
        chk("R4 disarm", gate_pin_o, 1'b1);

        // R5 repeated arm
        hwrite(1'b1, 8'hD1);
        hwrite(1'b1, 8'hD1);
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'hFD);
        chk("R5 repeated arm", gate_pin_o, 1'b0);

        // R6 consumed
        hwrite(1'b0, 8'hFF);
        chk("R6 consumed", gate_pin_o, 1'b0);

        // R10 strobe low: arm, wiggle bus, then data
        hwrite(1'b1, 8'hD1);
        host_is_cmd = 1'b1; host_byte = 8'h55; @(negedge clk);
        host_is_cmd = 1'b0; host_byte = 8'hFF; @(negedge clk);
        chk("R10 no strobe gate", gate_pin_o, 1'b0);
        hwrite(1'b0, 8'h02);
        chk("R10 still armed", gate_pin_o, 1'b1);

        // R7 disabled path
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h00);
        chk("R7 pre", gate_pin_o, 1'b0);
        gate_en = 1'b0;
        fw_gate = 1'b0;
        #1;
        chk("R7 fw 0", gate_pin_o, 1'b0);
        fw_gate = 1'b1;
        #1;
        chk("R7 fw 1", gate_pin_o, 1'b1);
        fw_gate = 1'b0;
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h02);
        chk("R7 writes ignored", gate_pin_o, 1'b0);
        gate_en = 1'b1;
        m_gate = 1'b1;
        m_armed = 1'b0;
        #1;
        chk("R7 re-enable high", gate_pin_o, 1'b1);
        hwrite(1'b0, 8'h00);
        chk("R7 not armed after re-enable", gate_pin_o, 1'b1);

        // R8 direction
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h00);
        pin_dir_out = 1'b0;
        #1;
        chk("R8 oe low", gate_pin_oe, 1'b0);
        chk("R8 level high", gate_pin_o, 1'b1);
        pin_dir_out = 1'b1;
        #1;
        chk("R8 oe high", gate_pin_oe, 1'b1);
        chk("R8 level restored", gate_pin_o, 1'b0);
        @(negedge clk);

        // R9 sweep of every data byte
        for (int b = 0; b < 256; b++) begin
            hwrite(1'b1, 8'hD1);
            hwrite(1'b0, b[7:0]);
            chk("R9 sweep", gate_pin_o, b[1]);
        end

        // R2..R6 mixed sequence against bench model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] v;
            int sel;
            v = 8'((i * 37 + 11) % 256);
            sel = (i * 7 + 3) % 5;
            if (sel == 0 || sel == 3) hwrite(1'b1, 8'hD1);
            else if (sel == 1) hwrite(1'b1, v == 8'hD1 ? 8'h00 : v);
            else hwrite(1'b0, v);
            chk("R2 mixed sequence", gate_pin_o, m_gate);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule